// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds one copy of a register for each hardware unit, and all the copies answer at a single address. A separate steering register selects one unit by a group number and an instance number, and it also holds a broadcast bit. A write to the shared address goes either to every copy or only to the steered copy, depending on that bit. A read of the shared address always returns the one steered copy, whatever the broadcast bit says.

A per-unit presence mask marks units that are fused off or power-gated. An access steered to an absent unit is terminated:

- a read of it returns zero;
- a unicast write to it is dropped;
- a broadcast write skips it.

No error is raised in any of these cases.

Requests are single-cycle. Each request carries a valid, a write flag, an address and write data. A read is answered by a response strobe and data exactly one cycle after the request. A small response state machine sets what the response shows. It has four states:

- `ST_IDLE`: no response.
- `ST_DATA`: steered copy data.
- `ST_SEL`: steering register readback.
- `ST_ZERO`: terminated or unmapped read.

Every cycle the state machine moves to the state chosen by the current request:

- A read of the steering address goes to `ST_SEL`.
- A read of the shared address with a present target goes to `ST_DATA`.
- Any other read goes to `ST_ZERO`.
- A write, or no request, goes to `ST_IDLE`.

Top module: `steered_reg_bank`

## Requirements
- R1: After reset every copy holds zero, and the steering register reads 0x0001_0000 (group 0, instance 0, broadcast on).
- R2: The steering register sits at `SEL_ADDR` and can be read and written. The instance field is at bits [3:0], the group field at bits [11:8] and the broadcast bit at bit 16. Field bits above the configured widths, and all other bits, read as zero.
- R3: A write to `REP_ADDR` with the broadcast bit set stores the data in every copy whose unit is present.
- R4: A broadcast write leaves the copies of absent units unchanged.
- R5: A write to `REP_ADDR` with the broadcast bit clear stores the data only in the copy of unit group*N_INST+instance.
- R6: A unicast write steered to an absent unit changes no copy.
- R7: A read of `REP_ADDR` returns the steered copy, with either value of the broadcast bit.
- R8: A read of `REP_ADDR` steered to an absent unit returns zero.
- R9: `rsp_valid` is high in the cycle after a read request and only then. It never follows a write or an idle cycle. `rsp_rdata` is zero whenever `rsp_valid` is low.
- R10: A read of any other address returns zero, and a write to any other address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| unit_avail | input | N_GROUPS*N_INST | Per-unit presence mask, 1 = present |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | DATA_W | Read response data |

## Verification
The bench targets reads made while the broadcast bit is still set. A design that let that bit steer reads would return the wrong copy or fail to compare. It also re-enables units after broadcast and unicast writes were made while they were absent. A design that wrote through a fused unit would then show non-zero data where only zero belongs. Reads steered to absent units, reads and writes to unmapped addresses, and back-to-back reads are all compared every cycle against a behavioural model. A wrong termination or a late response strobe therefore shows up at once. Random traffic with a changing presence mask then covers mixes of steering changes and accesses.

// File: rtl/srb_pkg.sv
package srb_pkg;

    // Response kind selected for the cycle after a request
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_SEL  = 2'd2,
        ST_ZERO = 2'd3
    } rsp_state_e;

    // Steering register layout
    localparam int SEL_INST_LSB = 0;
    localparam int SEL_GRP_LSB  = 8;
    localparam int SEL_MC_BIT   = 16;
    localparam int SEL_FIELD_MAX = 4;

endpackage

// File: rtl/srb_selector.sv
module srb_selector #(
    parameter int DATA_W = 32,
    parameter int GW     = 1,
    parameter int IW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [GW-1:0]     wr_grp,
    input  logic [IW-1:0]     wr_inst,
    input  logic              wr_mc,
    output logic [GW-1:0]     grp,
    output logic [IW-1:0]     inst,
    output logic              mcast,
    output logic [DATA_W-1:0] sel_word
);
    import srb_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp   <= '0;
            inst  <= '0;
            mcast <= 1'b1;
        end else if (wr_en) begin
            grp   <= wr_grp;
            inst  <= wr_inst;
            mcast <= wr_mc;
        end
    end

    always_comb begin
        sel_word                      = '0;
        sel_word[SEL_INST_LSB +: IW]  = inst;
        sel_word[SEL_GRP_LSB  +: GW]  = grp;
        sel_word[SEL_MC_BIT]          = mcast;
    end

endmodule

// File: rtl/srb_decode.sv
module srb_decode #(
    parameter int          ADDR_W   = 8,
    parameter int          N_GROUPS = 2,
    parameter int          N_INST   = 4,
    parameter int          GW       = 1,
    parameter int          IW       = 2,
    parameter int          N_UNITS  = 8,
    parameter int          UW       = 3,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] REP_ADDR = 8'h20
) (
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [GW-1:0]          grp,
    input  logic [IW-1:0]          inst,
    input  logic                   mcast,
    input  logic [N_UNITS-1:0]     unit_avail,
    output logic                   sel_we,
    output logic [N_UNITS-1:0]     unit_we,
    output srb_pkg::rsp_state_e    nxt_kind,
    output logic [UW-1:0]          tgt_idx
);
    import srb_pkg::*;

    logic hit_sel, hit_rep, rep_wr, grp_ok, inst_ok, tgt_ok;

    assign hit_sel = (req_addr == SEL_ADDR);
    assign hit_rep = (req_addr == REP_ADDR);
    assign sel_we  = req_valid && req_write && hit_sel;
    assign rep_wr  = req_valid && req_write && hit_rep;

    // Range checks only when a field can hold values past the count
    generate
        if (N_GROUPS == (1 << GW)) begin : g_grp_full
            assign grp_ok = 1'b1;
        end else begin : g_grp_chk
            assign grp_ok = ({1'b0, grp} < (GW+1)'(N_GROUPS));
        end
        if (N_INST == (1 << IW)) begin : g_inst_full
            assign inst_ok = 1'b1;
        end else begin : g_inst_chk
            assign inst_ok = ({1'b0, inst} < (IW+1)'(N_INST));
        end
    endgenerate

    assign tgt_idx = UW'(grp) * UW'(N_INST) + UW'(inst);
    assign tgt_ok  = grp_ok && inst_ok && unit_avail[tgt_idx];

    // Per-unit write enables: broadcast skips absent units, unicast needs a present target
    generate
        for (genvar u = 0; u < N_UNITS; u++) begin : g_we
            assign unit_we[u] = rep_wr &&
                                (mcast ? unit_avail[u]
                                       : (tgt_ok && (tgt_idx == UW'(u))));
        end
    endgenerate

    // Response kind; reads ignore the broadcast bit
    always_comb begin
        nxt_kind = ST_IDLE;
        if (req_valid && !req_write) begin
            if (hit_sel)
                nxt_kind = ST_SEL;
            else if (hit_rep && tgt_ok)
                nxt_kind = ST_DATA;
            else
                nxt_kind = ST_ZERO;
        end
    end

endmodule

// File: rtl/srb_storage.sv
module srb_storage #(
    parameter int DATA_W  = 32,
    parameter int N_UNITS = 8,
    parameter int UW      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_UNITS-1:0] unit_we,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [UW-1:0]      rd_idx,
    output logic [DATA_W-1:0]  rd_data
);
    logic [DATA_W-1:0] copy_q [N_UNITS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int u = 0; u < N_UNITS; u++)
                copy_q[u] <= '0;
        end else begin
            for (int u = 0; u < N_UNITS; u++)
                if (unit_we[u])
                    copy_q[u] <= wdata;
        end
    end

    assign rd_data = copy_q[rd_idx];

endmodule

// File: rtl/steered_reg_bank.sv
module steered_reg_bank #(
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 8,
    parameter int                N_GROUPS = 2,
    parameter int                N_INST   = 4,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] REP_ADDR = 8'h20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    input  logic [N_GROUPS*N_INST-1:0]   unit_avail,
    output logic                         rsp_valid,
    output logic [DATA_W-1:0]            rsp_rdata
);
    import srb_pkg::*;

    localparam int N_UNITS = N_GROUPS * N_INST;
    localparam int GW      = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;
    localparam int IW      = (N_INST   > 1) ? $clog2(N_INST)   : 1;
    localparam int UW      = (N_UNITS  > 1) ? $clog2(N_UNITS)  : 1;

    initial begin
        if (GW > SEL_FIELD_MAX || IW > SEL_FIELD_MAX)
            $error("steering fields exceed %0d bits", SEL_FIELD_MAX);
    end

    logic [GW-1:0]     sel_grp;
    logic [IW-1:0]     sel_inst;
    logic              sel_mc;
    logic [DATA_W-1:0] sel_word;
    logic              sel_we;
    logic [N_UNITS-1:0] unit_we;
    logic [UW-1:0]     tgt_idx;
    logic [DATA_W-1:0] stor_rd;
    rsp_state_e        nxt_kind, state_q;
    logic [DATA_W-1:0] cap_q;

    srb_selector #(.DATA_W(DATA_W), .GW(GW), .IW(IW)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sel_we),
        .wr_grp   (req_wdata[SEL_GRP_LSB +: GW]),
        .wr_inst  (req_wdata[SEL_INST_LSB +: IW]),
        .wr_mc    (req_wdata[SEL_MC_BIT]),
        .grp      (sel_grp),
        .inst     (sel_inst),
        .mcast    (sel_mc),
        .sel_word (sel_word)
    );

    srb_decode #(
        .ADDR_W(ADDR_W), .N_GROUPS(N_GROUPS), .N_INST(N_INST),
        .GW(GW), .IW(IW), .N_UNITS(N_UNITS), .UW(UW),
        .SEL_ADDR(SEL_ADDR), .REP_ADDR(REP_ADDR)
    ) u_dec (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .grp        (sel_grp),
        .inst       (sel_inst),
        .mcast      (sel_mc),
        .unit_avail (unit_avail),
        .sel_we     (sel_we),
        .unit_we    (unit_we),
        .nxt_kind   (nxt_kind),
        .tgt_idx    (tgt_idx)
    );

    srb_storage #(.DATA_W(DATA_W), .N_UNITS(N_UNITS), .UW(UW)) u_stor (
        .clk     (clk),
        .rst_n   (rst_n),
        .unit_we (unit_we),
        .wdata   (req_wdata),
        .rd_idx  (tgt_idx),
        .rd_data (stor_rd)
    );

    // State register with captured response word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cap_q   <= '0;
        end else begin
            state_q <= nxt_kind;
            cap_q   <= (nxt_kind == ST_SEL) ? sel_word : stor_rd;
        end
    end

    // Outputs per state
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin rsp_valid = 1'b0; rsp_rdata = '0;    end
            ST_DATA: begin rsp_valid = 1'b1; rsp_rdata = cap_q; end
            ST_SEL:  begin rsp_valid = 1'b1; rsp_rdata = cap_q; end
            ST_ZERO: begin rsp_valid = 1'b1; rsp_rdata = '0;    end
            default: begin rsp_valid = 1'b0; rsp_rdata = '0;    end
        endcase
    end

endmodule

// File: rtl/srb_checker.sv
module srb_checker #(
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 8,
    parameter int                N_GROUPS = 2,
    parameter int                N_INST   = 4,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] REP_ADDR = 8'h20
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_write,
    input logic [ADDR_W-1:0]          req_addr,
    input logic [N_GROUPS*N_INST-1:0] unit_avail,
    input logic                       rsp_valid,
    input logic [DATA_W-1:0]          rsp_rdata,
    input logic [DATA_W-1:0]          sel_word,
    input logic [((N_GROUPS > 1) ? $clog2(N_GROUPS) : 1)-1:0] sel_grp,
    input logic [((N_INST > 1) ? $clog2(N_INST) : 1)-1:0]     sel_inst
);
    localparam int N_UNITS = N_GROUPS * N_INST;
    localparam int UW      = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;

    logic          rd_req;
    logic [UW-1:0] steer_u;
    assign rd_req  = req_valid && !req_write;
    assign steer_u = UW'(sel_grp) * UW'(N_INST) + UW'(sel_inst);

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid); // R9

    AST_NO_RSP_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid); // R9

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_rdata == '0)); // R9

    AST_ABSENT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr == REP_ADDR && !unit_avail[steer_u]) |=> (rsp_rdata == '0)); // R8

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr != REP_ADDR && req_addr != SEL_ADDR) |=> (rsp_rdata == '0)); // R10

    AST_SEL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr == SEL_ADDR) |=> (rsp_rdata == $past(sel_word))); // R2

endmodule

bind steered_reg_bank srb_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_GROUPS(N_GROUPS), .N_INST(N_INST),
    .SEL_ADDR(SEL_ADDR), .REP_ADDR(REP_ADDR)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .unit_avail (unit_avail),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .sel_word   (sel_word),
    .sel_grp    (sel_grp),
    .sel_inst   (sel_inst)
);

// File: tb/steered_reg_bank_tb.sv
`timescale 1ns/1ps
module steered_reg_bank_tb_top;

    localparam logic [7:0] SEL_A = 8'h10;
    localparam logic [7:0] REP_A = 8'h20;
    localparam logic [7:0] OTH_A = 8'h33;
    localparam int NI = 4;
    localparam int NU = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  unit_avail = 8'hFF;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    always #4 clk = ~clk;

    steered_reg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .unit_avail(unit_avail),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string phase = "R1 reset";

    // Behavioural reference model
    logic [31:0] m_reg [NU];
    int          m_grp = 0, m_inst = 0;
    bit          m_mc = 1;
    logic        exp_valid = 0;
    logic [31:0] exp_data = '0;
    string       exp_tag = "R9";

    function automatic logic [31:0] selv(bit mc, int g, int i);
        return (32'(mc) << 16) | (32'(g) << 8) | 32'(i);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int u = 0; u < NU; u++) m_reg[u] = '0;
            m_grp = 0; m_inst = 0; m_mc = 1;
            exp_valid = 0; exp_data = '0; exp_tag = "R1";
        end else begin
            int t;
            t = m_grp * NI + m_inst;
            exp_valid = 0; exp_data = '0; exp_tag = "R9";
            if (req_valid && req_write) begin
                if (req_addr == SEL_A) begin
                    m_inst = int'(req_wdata[1:0]);
                    m_grp  = int'(req_wdata[8]);
                    m_mc   = req_wdata[16];
                end else if (req_addr == REP_A) begin
                    if (m_mc) begin
                        for (int u = 0; u < NU; u++)
                            if (unit_avail[u]) m_reg[u] = req_wdata;
                    end else if (unit_avail[t]) begin
                        m_reg[t] = req_wdata;
                    end
                end
            end else if (req_valid) begin
                exp_valid = 1;
                if (req_addr == SEL_A) begin
                    exp_data = selv(m_mc, m_grp, m_inst); exp_tag = "R2";
                end else if (req_addr == REP_A) begin
                    if (unit_avail[t]) begin exp_data = m_reg[t]; exp_tag = "R7"; end
                    else begin exp_data = '0; exp_tag = "R8"; end
                end else begin
                    exp_tag = "R10";
                end
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rsp_valid !== exp_valid || rsp_rdata !== exp_data) begin
                errors++;
                $display("FAIL %s [%s]: valid=%0b data=%h expected valid=%0b data=%h",
                         exp_tag, phase, rsp_valid, rsp_rdata, exp_valid, exp_data);
            end
        end
    end

    task automatic op(bit w, logic [7:0] a, logic [31:0] d);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = 1'b0; req_write = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_all(bit mc);
        for (int u = 0; u < NU; u++) begin
            op(1, SEL_A, selv(mc, u / NI, u % NI));
            op(0, REP_A, '0);
        end
        idle();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        phase = "R1 reset values";
        op(0, SEL_A, '0);
        idle();
        read_all(1);

        phase = "R3 R4 broadcast with absent units";
        unit_avail = 8'b1011_0110;
        op(1, SEL_A, selv(1, 0, 0));
        op(1, REP_A, 32'hA5A5_0001);
        idle();
        read_all(1);
        unit_avail = 8'hFF;
        read_all(1);

        phase = "R5 unicast";
        op(1, SEL_A, selv(0, 1, 2));
        op(1, REP_A, 32'h1234_5678);
        idle();
        read_all(0);

        phase = "R6 unicast to absent unit";
        unit_avail = 8'b1111_1110;
        op(1, SEL_A, selv(0, 0, 0));
        op(1, REP_A, 32'hDEAD_BEEF);
        op(0, REP_A, '0);
        idle();
        unit_avail = 8'hFF;
        op(0, REP_A, '0);
        idle();

        phase = "R7 read ignores broadcast bit";
        op(1, SEL_A, selv(1, 1, 2));
        op(0, REP_A, '0);
        op(1, SEL_A, selv(0, 1, 2));
        op(0, REP_A, '0);
        idle();

        phase = "R2 steering register unused bits";
        op(1, SEL_A, 32'hFFFF_FFFF);
        op(0, SEL_A, '0);
        op(1, SEL_A, 32'h0000_0F0F);
        op(0, SEL_A, '0);
        idle();

        phase = "R10 unmapped address";
        op(1, OTH_A, 32'h5555_AAAA);
        op(0, OTH_A, '0);
        op(0, SEL_A, '0);
        idle();
        read_all(0);

        phase = "R9 back-to-back reads";
        op(0, REP_A, '0);
        op(0, REP_A, '0);
        op(0, SEL_A, '0);
        op(1, REP_A, 32'h0BAD_F00D);
        op(0, REP_A, '0);
        idle();
        idle();

        phase = "R8 random traffic";
        for (int k = 0; k < 600; k++) begin
            int sel;
            if (k % 37 == 0) unit_avail = 8'($urandom);
            sel = int'($urandom % 5);
            if ($urandom % 4 == 0)
                idle();
            else
                op(1'($urandom), (sel == 0) ? SEL_A : (sel == 4) ? OTH_A : REP_A, $urandom);
        end
        unit_avail = 8'hFF;
        read_all(0);
        idle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule